// File: doc/BRIEF.md
# ADC Step Sequencer Controller

The block walks a table of sixteen conversion steps and drives an external successive-approximation converter through a small handshake. The controller raises a start-of-conversion strobe, the converter answers with a one-cycle done flag and a 12-bit sample, and the controller returns one result per step. Each step has its own settings: an input channel, a wait before the strobe, a strobe width and a sample count for averaging. When the count is above one, the step converts that many times and reports the mean.

Some steps are marked as touchscreen steps. Before the first enabled touchscreen step of a pass, the block runs a charge phase of programmable length. At the end of that phase it samples a touch-detect input. If no touch is seen, it pulses a pen-lifted flag and skips every remaining touchscreen step of that pass. Ordinary channel steps still run.

A pass starts from a start pulse and visits enabled steps in ascending order. At the end it either stops or wraps to step 0 for another pass. Dropping the run enable aborts the pass at once.

Top module: `adc_step_seq`

## Requirements
- R1: After reset, adc_start, charge_on, res_valid and pen_up are low and every table entry is disabled, so a start pulse produces no conversion and no result.
- R2: A write with cfg_we stores cfg_wdata into entry cfg_addr. The fields of cfg_wdata are open delay [17:0], sample width [25:18], channel [28:26], averaging code [31:29], touchscreen flag [32] and enable [33]. A pass begins when seq_start is high while run_en is high. It visits enabled entries in ascending index order, skips disabled entries, and tags each result with the entry index on res_tag.
- R3: For a non-touchscreen step 0, adc_start first goes high open+2 rising edges after the edge that samples seq_start.
- R4: Each assertion of adc_start lasts max(sample width, 1) cycles.
- R5: Averaging code c takes 2^c conversions, with codes above 4 treated as 4. The result is the sum of the samples divided by 2^c and truncated. A sum of sixteen full-scale samples does not overflow and returns 4095.
- R6: res_valid is high for exactly one cycle. It rises on the same clock edge that samples the final adc_done of the step.
- R7: After the last enabled entry, the block goes idle when loop_mode is low and produces nothing more. When loop_mode is high, it starts a new pass at entry 0.
- R8: While run_en is low, adc_start and charge_on are low from the next cycle on, and no further results appear.
- R9: The first enabled touchscreen step of each pass is preceded by exactly one charge phase, with charge_on high for max(chg_len, 1) cycles and adc_start low during that phase.
- R10: If pen_down is low in the last charge cycle, pen_up pulses for one cycle and all remaining touchscreen steps of that pass produce no result. Non-touchscreen steps still run.
- R11: adc_chan carries the channel field of the current step and does not change while adc_start is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 4 | Table entry index |
| cfg_wdata | input | 34 | Step entry contents |
| chg_len | input | 16 | Charge phase length in cycles |
| run_en | input | 1 | Run enable, aborts when low |
| seq_start | input | 1 | Starts a pass from idle |
| loop_mode | input | 1 | Wrap to entry 0 after the last step |
| pen_down | input | 1 | Touch detect from the front end |
| adc_start | output | 1 | Start-of-conversion strobe |
| adc_chan | output | 3 | Selected analog input |
| adc_done | input | 1 | Conversion complete pulse |
| adc_data | input | 12 | Conversion result |
| charge_on | output | 1 | Touchscreen charge phase active |
| pen_up | output | 1 | Pulse: no touch after charge |
| res_valid | output | 1 | Result pulse |
| res_data | output | 12 | Averaged step result |
| res_tag | output | 4 | Index of the step that produced the result |

## Verification
The hardest condition to reach is a pen-lifted pass. The touch-detect input must be low in exactly the last charge cycle, and several touchscreen steps must be queued behind that cycle so that skipping them can be seen. The bench programs three touchscreen steps followed by one ordinary step and holds pen_down low through the charge phase. It then checks that only the ordinary step's tag comes out. The same table is then rerun with the pen held down. Averaging is checked with a converter model that alternates between two values, so that any miscounted conversion or wrong shift changes the reported mean.

// File: rtl/adc_step_seq.sv
module adc_step_seq #(
  parameter int NSTEP   = 16,
  parameter int DW      = 12,
  parameter int OPEN_W  = 18,
  parameter int SAMP_W  = 8,
  parameter int CHG_W   = 16,
  parameter int CH_W    = 3,
  parameter int AVG_MAX = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [$clog2(NSTEP)-1:0]          cfg_addr,
  input  logic [OPEN_W+SAMP_W+CH_W+3+2-1:0] cfg_wdata,
  input  logic [CHG_W-1:0]                  chg_len,
  input  logic                              run_en,
  input  logic                              seq_start,
  input  logic                              loop_mode,
  input  logic                              pen_down,
  output logic                              adc_start,
  output logic [CH_W-1:0]                   adc_chan,
  input  logic                              adc_done,
  input  logic [DW-1:0]                     adc_data,
  output logic                              charge_on,
  output logic                              pen_up,
  output logic                              res_valid,
  output logic [DW-1:0]                     res_data,
  output logic [$clog2(NSTEP)-1:0]          res_tag
);
  localparam int IW    = $clog2(NSTEP);
  localparam int CFG_W = OPEN_W + SAMP_W + CH_W + 3 + 2;
  localparam int AW    = DW + AVG_MAX;
  localparam int NW    = AVG_MAX + 1;
  localparam int CW    = (OPEN_W > CHG_W) ? ((OPEN_W > SAMP_W) ? OPEN_W : SAMP_W)
                                          : ((CHG_W > SAMP_W) ? CHG_W : SAMP_W);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_CHG, S_OPEN, S_SOC, S_CONV, S_NEXT} st_t;

  st_t              state;
  logic [CFG_W-1:0] tbl [NSTEP];
  logic [IW-1:0]    idx;
  logic [CW-1:0]    cnt;
  logic [AW-1:0]    acc;
  logic [NW-1:0]    nleft;
  logic             charged, skip_t;

  logic [CFG_W-1:0]  cur;
  logic [OPEN_W-1:0] cur_open;
  logic [SAMP_W-1:0] cur_samp;
  logic [2:0]        cur_avg, avgc;
  logic              cur_touch, cur_en, last, go_next;
  logic [AW-1:0]     sum;

  assign cur       = tbl[idx];
  assign cur_open  = cur[OPEN_W-1:0];
  assign cur_samp  = cur[OPEN_W +: SAMP_W];
  assign cur_avg   = cur[OPEN_W+SAMP_W+CH_W +: 3];
  assign cur_touch = cur[CFG_W-2];
  assign cur_en    = cur[CFG_W-1];
  assign avgc      = (cur_avg > 3'(AVG_MAX)) ? 3'(AVG_MAX) : cur_avg;
  assign sum       = acc + AW'(adc_data);
  assign last      = (idx == IW'(NSTEP-1));
  assign go_next   = (state == S_NEXT) ||
                     (state == S_SCAN && (!cur_en || (cur_touch && skip_t)));

  assign adc_start = (state == S_SOC);
  assign charge_on = (state == S_CHG);
  assign adc_chan  = cur[OPEN_W+SAMP_W +: CH_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      cnt       <= '0;
      acc       <= '0;
      nleft     <= '0;
      charged   <= 1'b0;
      skip_t    <= 1'b0;
      pen_up    <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_tag   <= '0;
      for (int i = 0; i < NSTEP; i++) tbl[i] <= '0;
    end else begin
      res_valid <= 1'b0;
      pen_up    <= 1'b0;
      if (cfg_we) tbl[cfg_addr] <= cfg_wdata;
      if (!run_en) begin
        state <= S_IDLE;
      end else if (go_next) begin
        if (!last) begin
          idx   <= idx + IW'(1);
          state <= S_SCAN;
        end else if (loop_mode) begin
          idx     <= '0;
          charged <= 1'b0;
          skip_t  <= 1'b0;
          state   <= S_SCAN;
        end else begin
          state <= S_IDLE;
        end
      end else begin
        case (state)
          S_IDLE: if (seq_start) begin
            idx     <= '0;
            charged <= 1'b0;
            skip_t  <= 1'b0;
            state   <= S_SCAN;
          end
          S_SCAN: begin
            if (cur_touch && !charged) begin
              cnt   <= CW'(chg_len);
              state <= S_CHG;
            end else begin
              cnt   <= CW'(cur_open);
              acc   <= '0;
              nleft <= NW'((1 << avgc) - 1);
              state <= S_OPEN;
            end
          end
          S_CHG: begin
            if (cnt <= CW'(1)) begin
              charged <= 1'b1;
              if (!pen_down) begin
                skip_t <= 1'b1;
                pen_up <= 1'b1;
                state  <= S_SCAN;
              end else begin
                cnt   <= CW'(cur_open);
                acc   <= '0;
                nleft <= NW'((1 << avgc) - 1);
                state <= S_OPEN;
              end
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
          S_OPEN: begin
            if (cnt == '0) begin
              cnt   <= CW'(cur_samp);
              state <= S_SOC;
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
          S_SOC: begin
            if (cnt <= CW'(1)) state <= S_CONV;
            else               cnt   <= cnt - CW'(1);
          end
          S_CONV: if (adc_done) begin
            if (nleft == '0) begin
              res_valid <= 1'b1;
              res_data  <= DW'(sum >> avgc);
              res_tag   <= idx;
              state     <= S_NEXT;
            end else begin
              acc   <= sum;
              nleft <= nleft - NW'(1);
              cnt   <= CW'(cur_samp);
              state <= S_SOC;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module adc_step_seq_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run_en,
  input logic            adc_start,
  input logic [CH_W-1:0] adc_chan,
  input logic            adc_done,
  input logic            charge_on,
  input logic            pen_up,
  input logic            res_valid
);
  // R6
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R6
  res_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(adc_done));
  // R10
  penup_after_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pen_up |-> $past(charge_on));
  // R10
  penup_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pen_up |=> !pen_up);
  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!adc_start && !charge_on));
  // R11
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && $past(adc_start)) |-> $stable(adc_chan));
endmodule

bind adc_step_seq adc_step_seq_chk #(.CH_W(CH_W)) chk (.*);

// File: tb/adc_step_seq_test.sv
`timescale 1ns/1ps
module adc_step_seq_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = 0;
  logic [33:0] cfg_wdata = 0;
  logic [15:0] chg_len = 0;
  logic        run_en = 1, seq_start = 0, loop_mode = 0, pen_down = 1;
  logic        adc_start, charge_on, pen_up, res_valid;
  logic [2:0]  adc_chan;
  logic        adc_done = 0;
  logic [11:0] adc_data = 0;
  logic [11:0] res_data;
  logic [3:0]  res_tag;

  adc_step_seq uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int start_cyc, rise_cyc, first_w, n_conv, n_soc_total, chg_rise, chg_w, n_chg;
  int n_penup, pen_dbl, late, rv_dbl, chan_err, overlap, log_n;
  int log_tag [64];
  int log_data [64];
  int rise_chan;
  bit got_rise, w_pend, soc_q, chg_q, pen_q, rv_q;
  logic [2:0] chan_q;
  bit fullscale = 0, tog = 0, soc_m = 0;
  int dcnt = 0;

  initial begin
    {start_cyc, rise_cyc, first_w, n_conv, n_soc_total, chg_rise, chg_w, n_chg} = '0;
    {n_penup, pen_dbl, late, rv_dbl, chan_err, overlap, log_n, rise_chan} = '0;
  end

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (seq_start && run_en) begin start_cyc = cyc; got_rise = 0; n_conv = 0; end
    if (adc_start && !soc_q) begin
      n_conv++; n_soc_total++;
      if (!got_rise) begin got_rise = 1; rise_cyc = cyc; rise_chan = int'(adc_chan); w_pend = 1; end
    end
    if (!adc_start && soc_q && w_pend) begin first_w = cyc - rise_cyc; w_pend = 0; end
    if (adc_start && soc_q && adc_chan != chan_q) chan_err++;
    if (charge_on && !chg_q) begin chg_rise = cyc; n_chg++; end
    if (!charge_on && chg_q) chg_w = cyc - chg_rise;
    if (charge_on && adc_start) overlap++;
    if (pen_up) n_penup++;
    if (pen_up && pen_q) pen_dbl++;
    if (res_valid) begin
      if (log_n < 64) begin log_tag[log_n] = int'(res_tag); log_data[log_n] = int'(res_data); end
      log_n++;
      if (!adc_done) late++;
    end
    if (res_valid && rv_q) rv_dbl++;
    soc_q = adc_start; chg_q = charge_on; pen_q = pen_up; rv_q = res_valid; chan_q = adc_chan;
  end

  always @(negedge clk) begin
    #1;
    adc_done = 0;
    if (dcnt > 0) begin
      dcnt--;
      if (dcnt == 0) begin
        adc_done = 1;
        adc_data = fullscale ? 12'hFFF : 12'(int'(adc_chan) * 500 + 7 + (tog ? 6 : 0));
        tog = !tog;
      end
    end
    if (soc_m && !adc_start) dcnt = 3;
    soc_m = adc_start;
    if (res_valid || seq_start) tog = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input bit en, input bit tch, input int avg, input int ch,
                    input int samp, input int opn);
    @(negedge clk); #1;
    cfg_we = 1; cfg_addr = 4'(a);
    cfg_wdata = {en, tch, 3'(avg), 3'(ch), 8'(samp), 18'(opn)};
    @(negedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); #1; seq_start = 1;
    @(negedge clk); #1; seq_start = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); #1; rst_n = 0; loop_mode = 0; run_en = 1; pen_down = 1; fullscale = 0;
    repeat (3) @(negedge clk);
    #1; rst_n = 1;
  endtask

  task automatic wait_res(input int n);
    int t = 0;
    while (log_n < n && t < 20000) begin @(negedge clk); t++; end
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  localparam int NV = 5;
  localparam int V_CH   [NV] = '{0, 3, 5, 7, 2};
  localparam int V_AVG  [NV] = '{0, 1, 2, 4, 6};
  localparam int V_OPEN [NV] = '{0, 3, 10, 1, 0};
  localparam int V_SAMP [NV] = '{0, 1, 5, 2, 3};
  localparam int V_DLY  [NV] = '{2, 5, 12, 3, 2};
  localparam int V_W    [NV] = '{1, 1, 5, 2, 3};
  localparam int V_RES  [NV] = '{7, 1510, 2510, 3510, 1010};
  localparam int V_NCV  [NV] = '{1, 2, 4, 16, 16};

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired (all R) actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base, s, l, p, c;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk({adc_start, charge_on, res_valid, pen_up} == 4'b0, "R1 outputs after reset",
        int'({adc_start, charge_on, res_valid, pen_up}), 0);
    pulse_start();
    idle(200);
    chk(log_n == 0, "R1 no result from empty table", log_n, 0);
    chk(n_soc_total == 0, "R1 no conversion from empty table", n_soc_total, 0);

    for (int i = 0; i < NV; i++) begin
      wr(0, 1, 0, V_AVG[i], V_CH[i], V_SAMP[i], V_OPEN[i]);
      base = log_n;
      pulse_start();
      wait_res(base + 1);
      idle(40);
      chk(rise_cyc - start_cyc == V_DLY[i], "R3 open delay", rise_cyc - start_cyc, V_DLY[i]);
      chk(first_w == V_W[i], "R4 strobe width", first_w, V_W[i]);
      chk(log_data[base] == V_RES[i], "R5 averaged result", log_data[base], V_RES[i]);
      chk(n_conv == V_NCV[i], "R5 conversion count", n_conv, V_NCV[i]);
      chk(log_tag[base] == 0, "R2 result tag", log_tag[base], 0);
      chk(rise_chan == V_CH[i], "R11 channel select", rise_chan, V_CH[i]);
    end

    // R5 full scale, sixteen samples
    wr(0, 1, 0, 4, 1, 1, 0);
    fullscale = 1;
    base = log_n;
    pulse_start();
    wait_res(base + 1);
    idle(20);
    fullscale = 0;
    chk(log_data[base] == 4095, "R5 full-scale average", log_data[base], 4095);

    // R2 / R7 one-shot ordering with skipped entries
    do_reset();
    wr(2, 1, 0, 0, 1, 1, 2);
    wr(5, 1, 0, 0, 2, 1, 0);
    wr(15, 1, 0, 0, 3, 1, 1);
    base = log_n;
    pulse_start();
    wait_res(base + 3);
    idle(300);
    chk(log_n == base + 3, "R7 idle after last step", log_n - base, 3);
    chk(log_tag[base] == 2 && log_tag[base+1] == 5 && log_tag[base+2] == 15, "R2 step order",
        log_tag[base] * 10000 + log_tag[base+1] * 100 + log_tag[base+2], 20515);
    chk(log_data[base+2] == 1507, "R2 data of step 15", log_data[base+2], 1507);

    // R7 continuous wrap, then R8 abort
    do_reset();
    wr(1, 1, 0, 0, 4, 1, 0);
    wr(3, 1, 0, 1, 6, 1, 0);
    loop_mode = 1;
    base = log_n;
    pulse_start();
    wait_res(base + 4);
    chk(log_tag[base] == 1 && log_tag[base+1] == 3 && log_tag[base+2] == 1 && log_tag[base+3] == 3,
        "R7 wrap order", log_tag[base+2] * 10 + log_tag[base+3], 13);
    chk(log_data[base+3] == 3010, "R7 data on second pass", log_data[base+3], 3010);
    @(negedge clk); #1; run_en = 0;
    idle(2);
    s = n_soc_total; l = log_n; c = n_chg;
    idle(300);
    chk(n_soc_total == s && !adc_start, "R8 no strobe while disabled", n_soc_total - s, 0);
    chk(log_n == l, "R8 no result while disabled", log_n - l, 0);
    loop_mode = 0; run_en = 1;

    // R9 / R10 touchscreen, pen lifted
    do_reset();
    chg_len = 16'd20;
    wr(0, 1, 1, 0, 0, 1, 0);
    wr(1, 1, 1, 0, 1, 1, 0);
    wr(2, 1, 1, 0, 2, 1, 0);
    wr(4, 1, 0, 0, 6, 1, 0);
    pen_down = 0;
    base = log_n; p = n_penup; c = n_chg;
    pulse_start();
    wait_res(base + 1);
    idle(300);
    chk(log_n == base + 1 && log_tag[base] == 4, "R10 touch steps skipped", log_n - base, 1);
    chk(n_penup - p == 1, "R10 pen-up pulse count", n_penup - p, 1);
    chk(chg_w == 20, "R9 charge length", chg_w, 20);
    chk(n_chg - c == 1, "R9 one charge phase", n_chg - c, 1);

    // R9 / R10 touchscreen, pen held
    pen_down = 1;
    base = log_n; p = n_penup; c = n_chg;
    pulse_start();
    wait_res(base + 4);
    idle(300);
    chk(log_n == base + 4, "R10 all steps with pen down", log_n - base, 4);
    chk(log_tag[base] == 0 && log_tag[base+1] == 1 && log_tag[base+2] == 2 && log_tag[base+3] == 4,
        "R10 order with pen down", log_tag[base+3], 4);
    chk(n_penup == p, "R10 no pen-up pulse", n_penup - p, 0);
    chk(n_chg - c == 1, "R9 charge once per pass", n_chg - c, 1);
    chk(overlap == 0, "R9 no strobe during charge", overlap, 0);

    chk(late == 0, "R6 result on final done edge", late, 0);
    chk(rv_dbl == 0, "R6 single-cycle result", rv_dbl, 0);
    chk(pen_dbl == 0, "R10 single-cycle pen-up", pen_dbl, 0);
    chk(chan_err == 0, "R11 channel stable during strobe", chan_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule